// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves incoming frames from a valid/ready word stream into a packet memory and reports each one to the host through a ring of eight receive descriptors. Each descriptor takes three words in a 32-word descriptor memory, at a stride of four words. For descriptor `i`, word address `{i,2'b00}` is the control word, `{i,2'b01}` the timestamp word and `{i,2'b10}` the buffer word. The host arms a descriptor by writing a byte offset and a buffer size into its buffer word and then setting the ownership bit (bit 0 of the control word, 1 = the engine may fill it).

When a frame starts and reception is enabled, the engine reads the descriptor at the current ring index. If that descriptor is armed, the engine claims it and stores the frame words at consecutive packet-memory word addresses. Once the frame ends, it writes back the buffer word, the timestamp word and the control word, in that order. If the descriptor is not armed, the ring is full: the engine swallows the frame and raises a buffer-not-available flag. A side tag sampled with the last word of the frame carries the source port, a split timestamp (rising-edge count and falling-edge phase), a timestamp-present bit and a timestamp-suspect bit.

Completion sets a sticky frame-received flag, which is cleared by a one-cycle pulse, and a level interrupt, which is cleared by an acknowledge pulse. Both memories are outside the block. The descriptor memory has a one-cycle synchronous read.

Top module: `rxring_engine`

## Requirements
- R1: After reset, `s_ready`, `irq_rcomp`, `stat_rcvd` and `stat_bna` are 0 and `cur_desc` is 0.
- R2: A frame is claimed only if bit 0 of the control word at the current index is 1. Word k of the frame is written to packet word address offset[15:2]+k, where offset is bits 15:0 of the buffer word.
- R3: After reception, the buffer word becomes {length[15:0], offset[15:0]}. The offset is unchanged, and length in bytes = 4*(n-1)+t for n words, where t = `s_tail` of the last word and t = 0 means 4.
- R4: The timestamp word is written as {fall[3:0] in bits 31:28, rise[27:0] in bits 27:0}.
- R5: The control word is written last, with bit 0 = 0, bit 1 = error, bits 13:8 = port, bit 14 = timestamp present, bit 15 = timestamp suspect and all other bits 0. No write ever goes to a descriptor's fourth word.
- R6: The buffer holds floor(size/4) words, where size is bits 31:16 of the buffer word. Words beyond that are accepted but not written. The length written is 4*capacity and the error bit is set.
- R7: An error flagged on the last word sets the error bit of the control word.
- R8: If the current descriptor is not armed, the frame is accepted and discarded with no packet write, `stat_bna` becomes 1 and `cur_desc` is unchanged. `stat_bna` returns to 0 when a later frame claims a descriptor.
- R9: `cur_desc` advances by one after each stored frame and wraps from 7 to 0.
- R10: `stat_rcvd` is set by each stored frame and cleared by a `rcvd_clr` pulse. A new completion takes priority over the clear.
- R11: `irq_rcomp` goes high with each stored frame and stays high until an `irq_ack` pulse. A new completion takes priority over the acknowledge.
- R12: While `rx_en` is 0, no new frame is started: `s_ready` stays 0 and nothing is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Allows new frames to be started |
| s_valid | input | 1 | Frame word valid |
| s_data | input | 32 | Frame word |
| s_last | input | 1 | Last word of frame |
| s_tail | input | 2 | Valid bytes in last word, 0 = 4 |
| s_err | input | 1 | Upstream error, sampled with last word |
| s_ready | output | 1 | Engine accepts a word |
| tag_port | input | 6 | Source port number |
| tag_ts_rise | input | 28 | Rising-edge timestamp count |
| tag_ts_fall | input | 4 | Falling-edge timestamp phase |
| tag_ts_ok | input | 1 | Timestamp present |
| tag_ts_bad | input | 1 | Timestamp may be wrong |
| desc_addr | output | 5 | Descriptor memory word address |
| desc_we | output | 1 | Descriptor memory write enable |
| desc_wdata | output | 32 | Descriptor memory write data |
| desc_rdata | input | 32 | Descriptor memory read data, one cycle after address |
| pkt_addr | output | 14 | Packet memory word address |
| pkt_we | output | 1 | Packet memory write enable |
| pkt_wdata | output | 32 | Packet memory write data |
| stat_bna | output | 1 | No armed descriptor on last frame start |
| stat_rcvd | output | 1 | Sticky frame-received flag |
| rcvd_clr | input | 1 | Clears the frame-received flag |
| irq_rcomp | output | 1 | Receive-complete interrupt, level |
| irq_ack | input | 1 | Acknowledges the interrupt |
| cur_desc | output | 3 | Current ring index |

## Verification
The frame path is driven with several patterns:
- Multi-word frames whose last word is partial separate the byte-length arithmetic from plain word counting.
- A clean frame and an errored frame with a suspect timestamp separate the control-word bit positions from each other.
- A frame longer than its buffer shows whether extra words leak past the buffer end.
- A frame arriving at an unarmed descriptor shows whether the engine writes anything or moves the index.

Single-word frames across eight slots exercise the ring wrap. A frame held at the input while reception is disabled shows that nothing starts until the enable returns.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_CTL, ST_CHK_CTL, ST_CHK_BUF, ST_RECV,
    ST_DROP, ST_WB_BUF, ST_WB_TS, ST_WB_CTL
  } rxr_state_e;

  // Word select within one descriptor slot
  localparam logic [1:0] SUB_CTL = 2'd0;
  localparam logic [1:0] SUB_TS  = 2'd1;
  localparam logic [1:0] SUB_BUF = 2'd2;

  // Control word bit positions
  localparam int POS_OWN   = 0;
  localparam int POS_ERR   = 1;
  localparam int POS_PORT  = 8;
  localparam int POS_TSOK  = 14;
  localparam int POS_TSBAD = 15;

  localparam int WORD_W = 32;
endpackage

// File: rtl/rxr_rst_sync.sv
module rxr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rxr_seq.sv
module rxr_seq
  import rxr_pkg::*;
#(
  parameter int N_DESC = 8,
  parameter int IDX_W  = $clog2(N_DESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             s_valid,
  input  logic             s_last,
  input  logic             own_bit,
  output logic             s_ready,
  output logic [1:0]       sub_sel,
  output logic             desc_we,
  output logic             load,
  output logic             acc,
  output logic             claim,
  output logic             drop,
  output logic             done,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_DESC - 1);

  rxr_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    s_ready = 1'b0;
    sub_sel = SUB_CTL;
    desc_we = 1'b0;
    load    = 1'b0;
    acc     = 1'b0;
    claim   = 1'b0;
    drop    = 1'b0;
    done    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (rx_en && s_valid) st_d = ST_RD_CTL;
      end
      ST_RD_CTL: begin
        sub_sel = SUB_CTL;
        st_d    = ST_CHK_CTL;
      end
      ST_CHK_CTL: begin
        sub_sel = SUB_BUF;
        if (own_bit) begin
          st_d = ST_CHK_BUF;
        end else begin
          st_d = ST_DROP;
          drop = 1'b1;
        end
      end
      ST_CHK_BUF: begin
        load  = 1'b1;
        claim = 1'b1;
        st_d  = ST_RECV;
      end
      ST_RECV: begin
        s_ready = 1'b1;
        if (s_valid) begin
          acc = 1'b1;
          if (s_last) st_d = ST_WB_BUF;
        end
      end
      ST_DROP: begin
        s_ready = 1'b1;
        if (s_valid && s_last) st_d = ST_IDLE;
      end
      ST_WB_BUF: begin
        sub_sel = SUB_BUF;
        desc_we = 1'b1;
        st_d    = ST_WB_TS;
      end
      ST_WB_TS: begin
        sub_sel = SUB_TS;
        desc_we = 1'b1;
        st_d    = ST_WB_CTL;
      end
      ST_WB_CTL: begin
        sub_sel = SUB_CTL;
        desc_we = 1'b1;
        done    = 1'b1;
        idx_d   = (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;
endmodule

// File: rtl/rxr_fill.sv
module rxr_fill #(
  parameter int AW    = 14,
  parameter int LEN_W = AW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    cap,
  input  logic             acc,
  input  logic             last,
  input  logic [1:0]       tail,
  output logic             pkt_we,
  output logic [AW-1:0]    pkt_addr,
  output logic [LEN_W-1:0] len_bytes,
  output logic             ovf
);
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] cap_q, cap_d;
  logic [AW-1:0] wcnt_q, wcnt_d;
  logic          ovf_q, ovf_d;
  logic [1:0]    tail_q, tail_d;
  logic          room;
  logic [2:0]    short_by;

  assign room     = (wcnt_q != cap_q);
  assign pkt_we   = acc && room;
  assign pkt_addr = base_q + wcnt_q;

  always_comb begin
    base_d = base_q;
    cap_d  = cap_q;
    wcnt_d = wcnt_q;
    ovf_d  = ovf_q;
    tail_d = tail_q;
    if (load) begin
      base_d = base;
      cap_d  = cap;
      wcnt_d = '0;
      ovf_d  = 1'b0;
      tail_d = 2'd0;
    end else if (acc) begin
      if (room) wcnt_d = wcnt_q + 1'b1;
      else      ovf_d  = 1'b1;
      if (last) tail_d = tail;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cap_q  <= '0;
      wcnt_q <= '0;
      ovf_q  <= 1'b0;
      tail_q <= 2'd0;
    end else begin
      base_q <= base_d;
      cap_q  <= cap_d;
      wcnt_q <= wcnt_d;
      ovf_q  <= ovf_d;
      tail_q <= tail_d;
    end
  end

  // A partial last word shortens the byte count; a truncated frame keeps full words.
  assign short_by  = (ovf_q || tail_q == 2'd0) ? 3'd0 : (3'd4 - {1'b0, tail_q});
  assign len_bytes = {wcnt_q, 2'b00} - LEN_W'(short_by);
  assign ovf       = ovf_q;
endmodule

// File: rtl/rxr_wbfmt.sv
module rxr_wbfmt
  import rxr_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int PORT_W = 6,
  parameter int TSR_W  = 28,
  parameter int TSF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  offset_in,
  input  logic              cap_tag,
  input  logic              s_err,
  input  logic [PORT_W-1:0] tag_port,
  input  logic [TSR_W-1:0]  tag_ts_rise,
  input  logic [TSF_W-1:0]  tag_ts_fall,
  input  logic              tag_ts_ok,
  input  logic              tag_ts_bad,
  input  logic [1:0]        sub_sel,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic              ovf,
  output logic [WORD_W-1:0] wdata
);
  logic [LEN_W-1:0]  off_q, off_d;
  logic              err_q, err_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic [TSR_W-1:0]  rise_q, rise_d;
  logic [TSF_W-1:0]  fall_q, fall_d;
  logic              ok_q, ok_d, bad_q, bad_d;

  always_comb begin
    off_d  = off_q;
    err_d  = err_q;
    port_d = port_q;
    rise_d = rise_q;
    fall_d = fall_q;
    ok_d   = ok_q;
    bad_d  = bad_q;
    if (load) off_d = offset_in;
    if (cap_tag) begin
      err_d  = s_err;
      port_d = tag_port;
      rise_d = tag_ts_rise;
      fall_d = tag_ts_fall;
      ok_d   = tag_ts_ok;
      bad_d  = tag_ts_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      err_q  <= 1'b0;
      port_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      ok_q   <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      off_q  <= off_d;
      err_q  <= err_d;
      port_q <= port_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      ok_q   <= ok_d;
      bad_q  <= bad_d;
    end
  end

  always_comb begin
    wdata = '0;
    case (sub_sel)
      SUB_BUF: wdata = {len_bytes, off_q};
      SUB_TS: begin
        wdata[TSR_W-1:0]      = rise_q;
        wdata[TSR_W +: TSF_W] = fall_q;
      end
      default: begin
        wdata[POS_OWN]            = 1'b0;
        wdata[POS_ERR]            = err_q | ovf;
        wdata[POS_PORT +: PORT_W] = port_q;
        wdata[POS_TSOK]           = ok_q;
        wdata[POS_TSBAD]          = bad_q;
      end
    endcase
  end
endmodule

// File: rtl/rxr_status.sv
module rxr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic claim,
  input  logic drop,
  input  logic done,
  input  logic rcvd_clr,
  input  logic irq_ack,
  output logic stat_bna,
  output logic stat_rcvd,
  output logic irq_rcomp
);
  logic bna_q, bna_d, rcvd_q, rcvd_d, irq_q, irq_d;

  always_comb begin
    bna_d  = bna_q;
    rcvd_d = rcvd_q;
    irq_d  = irq_q;
    if (drop)       bna_d = 1'b1;
    else if (claim) bna_d = 1'b0;
    if (done)          rcvd_d = 1'b1;
    else if (rcvd_clr) rcvd_d = 1'b0;
    if (done)         irq_d = 1'b1;
    else if (irq_ack) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bna_q  <= 1'b0;
      rcvd_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      bna_q  <= bna_d;
      rcvd_q <= rcvd_d;
      irq_q  <= irq_d;
    end
  end

  assign stat_bna  = bna_q;
  assign stat_rcvd = rcvd_q;
  assign irq_rcomp = irq_q;
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
  import rxr_pkg::*;
#(
  parameter int N_DESC = 8,
  parameter int LEN_W  = 16,
  parameter int PORT_W = 6,
  parameter int TSR_W  = 28,
  parameter int TSF_W  = 4,
  localparam int IDX_W   = $clog2(N_DESC),
  localparam int DESC_AW = IDX_W + 2,
  localparam int PKT_AW  = LEN_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               s_valid,
  input  logic [WORD_W-1:0]  s_data,
  input  logic               s_last,
  input  logic [1:0]         s_tail,
  input  logic               s_err,
  output logic               s_ready,
  input  logic [PORT_W-1:0]  tag_port,
  input  logic [TSR_W-1:0]   tag_ts_rise,
  input  logic [TSF_W-1:0]   tag_ts_fall,
  input  logic               tag_ts_ok,
  input  logic               tag_ts_bad,
  output logic [DESC_AW-1:0] desc_addr,
  output logic               desc_we,
  output logic [WORD_W-1:0]  desc_wdata,
  input  logic [WORD_W-1:0]  desc_rdata,
  output logic [PKT_AW-1:0]  pkt_addr,
  output logic               pkt_we,
  output logic [WORD_W-1:0]  pkt_wdata,
  output logic               stat_bna,
  output logic               stat_rcvd,
  input  logic               rcvd_clr,
  output logic               irq_rcomp,
  input  logic               irq_ack,
  output logic [IDX_W-1:0]   cur_desc
);
  logic             rst_n_i;
  logic [1:0]       sub_sel;
  logic             load, acc, claim, drop, done;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] len_bytes;
  logic             ovf;
  logic             unused_rd;

  assign unused_rd = ^{desc_rdata[WORD_W-1:LEN_W+PKT_AW+2], desc_rdata[LEN_W+1:LEN_W], desc_rdata[1]};

  rxr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  rxr_seq #(.N_DESC(N_DESC), .IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .rx_en   (rx_en),
    .s_valid (s_valid),
    .s_last  (s_last),
    .own_bit (desc_rdata[POS_OWN]),
    .s_ready (s_ready),
    .sub_sel (sub_sel),
    .desc_we (desc_we),
    .load    (load),
    .acc     (acc),
    .claim   (claim),
    .drop    (drop),
    .done    (done),
    .idx     (idx)
  );

  rxr_fill #(.AW(PKT_AW), .LEN_W(LEN_W)) u_fill (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (load),
    .base      (desc_rdata[LEN_W-1:2]),
    .cap       (desc_rdata[LEN_W+2 +: PKT_AW]),
    .acc       (acc),
    .last      (s_last),
    .tail      (s_tail),
    .pkt_we    (pkt_we),
    .pkt_addr  (pkt_addr),
    .len_bytes (len_bytes),
    .ovf       (ovf)
  );

  rxr_wbfmt #(.LEN_W(LEN_W), .PORT_W(PORT_W), .TSR_W(TSR_W), .TSF_W(TSF_W)) u_fmt (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .load        (load),
    .offset_in   (desc_rdata[LEN_W-1:0]),
    .cap_tag     (acc && s_last),
    .s_err       (s_err),
    .tag_port    (tag_port),
    .tag_ts_rise (tag_ts_rise),
    .tag_ts_fall (tag_ts_fall),
    .tag_ts_ok   (tag_ts_ok),
    .tag_ts_bad  (tag_ts_bad),
    .sub_sel     (sub_sel),
    .len_bytes   (len_bytes),
    .ovf         (ovf),
    .wdata       (desc_wdata)
  );

  rxr_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .claim     (claim),
    .drop      (drop),
    .done      (done),
    .rcvd_clr  (rcvd_clr),
    .irq_ack   (irq_ack),
    .stat_bna  (stat_bna),
    .stat_rcvd (stat_rcvd),
    .irq_rcomp (irq_rcomp)
  );

  assign desc_addr = {idx, sub_sel};
  assign pkt_wdata = s_data;
  assign cur_desc  = idx;
endmodule

// File: rtl/rxr_checks.sv
module rxr_checks #(
  parameter int N_DESC  = 8,
  parameter int IDX_W   = 3,
  parameter int DESC_AW = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               s_valid,
  input logic               s_ready,
  input logic               pkt_we,
  input logic               desc_we,
  input logic [DESC_AW-1:0] desc_addr,
  input logic [31:0]        desc_wdata,
  input logic               irq_rcomp,
  input logic               irq_ack,
  input logic               stat_rcvd,
  input logic               rcvd_clr,
  input logic [IDX_W-1:0]   cur_desc
);
  logic ctl_wr;
  assign ctl_wr = desc_we && (desc_addr[1:0] == 2'd0);

  // R2: packet writes happen only on an accepted word
  assert_pkt_on_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_we |-> (s_valid && s_ready));

  // R5: the fourth word of a slot is never written
  assert_no_spare_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    desc_we |-> (desc_addr[1:0] != 2'd3));

  // R5: a control writeback always hands the slot back
  assert_ctl_handback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |-> !desc_wdata[0]);

  // R9: ring index moves only by one step, wrapping
  assert_idx_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_desc != $past(cur_desc)) |->
      (cur_desc == (($past(cur_desc) == IDX_W'(N_DESC - 1)) ? '0 : $past(cur_desc) + 1'b1)));

  // R11: interrupt rises only after a control writeback
  assert_irq_after_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_rcomp) |-> $past(ctl_wr));

  // R11: acknowledge without a completion lowers the interrupt
  assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !ctl_wr) |=> !irq_rcomp);

  // R10: clear without a completion lowers the received flag
  assert_rcvd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rcvd_clr && !ctl_wr) |=> !stat_rcvd);
endmodule

bind rxring_engine rxr_checks #(.N_DESC(N_DESC), .IDX_W(IDX_W), .DESC_AW(DESC_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_valid    (s_valid),
  .s_ready    (s_ready),
  .pkt_we     (pkt_we),
  .desc_we    (desc_we),
  .desc_addr  (desc_addr),
  .desc_wdata (desc_wdata),
  .irq_rcomp  (irq_rcomp),
  .irq_ack    (irq_ack),
  .stat_rcvd  (stat_rcvd),
  .rcvd_clr   (rcvd_clr),
  .cur_desc   (cur_desc)
);

// File: tb/rxring_engine_bench.sv
module rxring_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_last = 1'b0;
  logic [1:0]  s_tail = '0;
  logic        s_err = 1'b0;
  logic        s_ready;
  logic [5:0]  tag_port = '0;
  logic [27:0] tag_ts_rise = '0;
  logic [3:0]  tag_ts_fall = '0;
  logic        tag_ts_ok = 1'b0;
  logic        tag_ts_bad = 1'b0;
  logic [4:0]  desc_addr;
  logic        desc_we;
  logic [31:0] desc_wdata;
  logic [31:0] desc_rdata;
  logic [13:0] pkt_addr;
  logic        pkt_we;
  logic [31:0] pkt_wdata;
  logic        stat_bna, stat_rcvd, irq_rcomp;
  logic        rcvd_clr = 1'b0;
  logic        irq_ack = 1'b0;
  logic [2:0]  cur_desc;

  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] dmem [0:31];
  logic [31:0] pmem [0:4095];
  int          nwr;
  int          checks = 0;
  int          failures = 0;

  always #4 clk = ~clk;

  rxring_engine u_rxring_engine (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_tail(s_tail),
    .s_err(s_err), .s_ready(s_ready),
    .tag_port(tag_port), .tag_ts_rise(tag_ts_rise), .tag_ts_fall(tag_ts_fall),
    .tag_ts_ok(tag_ts_ok), .tag_ts_bad(tag_ts_bad),
    .desc_addr(desc_addr), .desc_we(desc_we), .desc_wdata(desc_wdata),
    .desc_rdata(desc_rdata),
    .pkt_addr(pkt_addr), .pkt_we(pkt_we), .pkt_wdata(pkt_wdata),
    .stat_bna(stat_bna), .stat_rcvd(stat_rcvd), .rcvd_clr(rcvd_clr),
    .irq_rcomp(irq_rcomp), .irq_ack(irq_ack), .cur_desc(cur_desc)
  );

  always @(posedge clk) begin
    if (host_we) dmem[host_addr] <= host_wdata;
    if (desc_we) dmem[desc_addr] <= desc_wdata;
    desc_rdata <= dmem[desc_addr];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) nwr <= 0;
    else if (pkt_we) begin
      pmem[pkt_addr[11:0]] <= pkt_wdata;
      nwr <= nwr + 1;
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [31:0] d);
    host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic arm(input int i, input logic [15:0] off, input logic [15:0] size);
    host_wr(i * 4 + 2, {size, off});
    host_wr(i * 4 + 1, 32'h0);
    host_wr(i * 4, 32'h1);
  endtask

  function automatic logic [15:0] exp_len(input int n, input logic [1:0] t);
    return (t == 2'd0) ? 16'(4 * n) : 16'(4 * (n - 1) + t);
  endfunction

  task automatic send_frame(input int n, input logic [31:0] d0, input logic [1:0] t,
                            input logic e, input logic [5:0] p, input logic [27:0] r,
                            input logic [3:0] f, input logic ok, input logic bad);
    tag_port = p; tag_ts_rise = r; tag_ts_fall = f; tag_ts_ok = ok; tag_ts_bad = bad;
    for (int k = 0; k < n; k++) begin
      s_valid = 1'b1; s_data = d0 + 32'(k); s_last = (k == n - 1);
      s_tail = t; s_err = (k == n - 1) && e;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 s_ready", 32'(s_ready), 0);
    chk("R1 irq", 32'(irq_rcomp), 0);
    chk("R1 rcvd", 32'(stat_rcvd), 0);
    chk("R1 bna", 32'(stat_bna), 0);
    chk("R1 cur_desc", 32'(cur_desc), 0);
  endtask

  task automatic t_basic;
    int base = nwr;
    arm(0, 16'h0040, 16'd64);
    send_frame(5, 32'hA000_0000, 2'd2, 1'b0, 6'd37, 28'h0ABCDEF, 4'h9, 1'b1, 1'b0);
    chk("R2 write count", 32'(nwr - base), 5);
    for (int k = 0; k < 5; k++) chk("R2 packet data", pmem[16 + k], 32'hA000_0000 + 32'(k));
    chk("R3 buffer word", dmem[2], {exp_len(5, 2'd2), 16'h0040});
    chk("R4 timestamp word", dmem[1], 32'h90AB_CDEF);
    chk("R5 control word", dmem[0], 32'h0000_6500);
    chk("R9 index step", 32'(cur_desc), 1);
    chk("R10 rcvd set", 32'(stat_rcvd), 1);
    chk("R11 irq set", 32'(irq_rcomp), 1);
  endtask

  task automatic t_status_clear;
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R11 irq cleared", 32'(irq_rcomp), 0);
    chk("R10 rcvd kept by ack", 32'(stat_rcvd), 1);
    rcvd_clr = 1'b1; @(negedge clk); rcvd_clr = 1'b0;
    chk("R10 rcvd cleared", 32'(stat_rcvd), 0);
  endtask

  task automatic t_error_suspect;
    arm(1, 16'h0100, 16'd32);
    send_frame(3, 32'hB000_0000, 2'd0, 1'b1, 6'd5, 28'h1234567, 4'h3, 1'b0, 1'b1);
    chk("R7 control word with error", dmem[4], 32'h0000_8502);
    chk("R3 full-word length", dmem[6], {exp_len(3, 2'd0), 16'h0100});
    chk("R4 timestamp word", dmem[5], 32'h3123_4567);
  endtask

  task automatic t_truncate;
    int base = nwr;
    arm(2, 16'h0200, 16'd8);
    send_frame(4, 32'hC000_0000, 2'd0, 1'b0, 6'd0, 28'h0, 4'h0, 1'b0, 1'b0);
    chk("R6 words stored", 32'(nwr - base), 2);
    chk("R6 last stored word", pmem[129], 32'hC000_0001);
    chk("R6 length capped", dmem[10], 32'h0008_0200);
    chk("R6 error bit", dmem[8], 32'h0000_0002);
    chk("R9 index", 32'(cur_desc), 3);
  endtask

  task automatic t_no_buffer;
    int base;
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    host_wr(12, 32'h0);
    base = nwr;
    send_frame(3, 32'hD000_0000, 2'd0, 1'b0, 6'd1, 28'h0, 4'h0, 1'b0, 1'b0);
    chk("R8 nothing written", 32'(nwr - base), 0);
    chk("R8 bna set", 32'(stat_bna), 1);
    chk("R8 index held", 32'(cur_desc), 3);
    chk("R8 slot untouched", dmem[12], 32'h0);
    chk("R8 no irq", 32'(irq_rcomp), 0);
    arm(3, 16'h0300, 16'd64);
    send_frame(2, 32'hD100_0000, 2'd0, 1'b0, 6'd2, 28'h0, 4'h0, 1'b0, 1'b0);
    chk("R8 bna cleared", 32'(stat_bna), 0);
    chk("R8 recovered frame", dmem[14], 32'h0008_0300);
    chk("R2 recovered data", pmem[193], 32'hD100_0001);
  endtask

  task automatic t_disabled;
    int base = nwr;
    arm(4, 16'h0380, 16'd64);
    rx_en = 1'b0;
    s_valid = 1'b1; s_data = 32'hE000_0000; s_last = 1'b0;
    repeat (10) @(negedge clk);
    chk("R12 ready held low", 32'(s_ready), 0);
    chk("R12 nothing written", 32'(nwr - base), 0);
    chk("R12 slot still armed", dmem[16], 32'h1);
    rx_en = 1'b1;
    send_frame(2, 32'hE000_0000, 2'd1, 1'b0, 6'd9, 28'h0, 4'h0, 1'b0, 1'b0);
    chk("R12 frame after enable", dmem[18], {exp_len(2, 2'd1), 16'h0380});
    chk("R9 index", 32'(cur_desc), 5);
  endtask

  task automatic t_wrap;
    arm(5, 16'h0400, 16'd16);
    arm(6, 16'h0500, 16'd16);
    arm(7, 16'h0600, 16'd16);
    arm(0, 16'h0700, 16'd16);
    for (int k = 0; k < 3; k++)
      send_frame(1, 32'hF000_0000 + 32'(k), 2'd3, 1'b0, 6'd0, 28'h0, 4'h0, 1'b0, 1'b0);
    chk("R9 wrap to zero", 32'(cur_desc), 0);
    send_frame(1, 32'hF000_0010, 2'd3, 1'b0, 6'd0, 28'h0, 4'h0, 1'b0, 1'b0);
    chk("R9 after wrap", 32'(cur_desc), 1);
    chk("R3 tail-three length", dmem[2], {exp_len(1, 2'd3), 16'h0700});
    chk("R2 wrapped data", pmem[12'h1C0], 32'hF000_0010);
    chk("R2 slot seven data", pmem[12'h180], 32'hF000_0002);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_addr = 5'(i); host_wdata = 32'h0;
    end
    @(negedge clk);
    host_we = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    rx_en = 1'b1;
    t_basic;
    t_status_clear;
    t_error_suspect;
    t_truncate;
    t_no_buffer;
    t_disabled;
    t_wrap;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule